// File: doc/BRIEF.md
# Clocked Bus Read Sequencer with Wait-State Stretching

This block is a bus master that turns a single local request into one memory read cycle built from whole clock states. In the first state it puts the target address on the bus. In the second state it raises the read strobe while the address stays in place. From then on it samples the memory's ready line on every rising edge. The first edge that finds ready high latches the bus data and ends the cycle.

A slow memory pulls ready low as soon as it sees the read strobe and raises it once its data is valid. Each edge that finds ready low adds one more state, and address and read stay exactly as they were. A parameter sets the most wait states the sequencer will tolerate. One more low sample beyond that limit aborts the cycle and raises an error pulse in place of the completion pulse.

Top module: `sync_read_master`

## Requirements
- R1: A synchronous active-high reset, applied at any point including mid-cycle, leaves the bus address at zero, read low, the done pulse low and the error pulse low from the next clock onward.
- R2: A start request sampled high in idle puts the requested address on the bus in the next state, with read still low.
- R3: In the following state the read strobe goes high and the address is unchanged.
- R4: The edge that ends the read-strobe state is the first ready sample. On any such sample that finds ready high, the bus data present at that edge appears on the captured-data output together with a done pulse exactly one clock long.
- R5: Each edge that samples ready low inserts one wait state in which address and read hold their values. A memory that keeps ready low for D edges therefore completes D clocks later than a ready memory.
- R6: In the state after capture, the bus address returns to zero and read goes low. The next state is idle and can accept a new start.
- R7: A start request raised while a cycle is in progress is ignored. The bus address keeps the original target and no second cycle follows.
- R8: When ready is still low on the sample after MAX_WAIT wait states have been inserted, the cycle aborts. The error output pulses high for one clock, the done pulse stays low, read and address drop, and the captured-data output keeps its previous value.
- R9: If ready rises on exactly the sample at which MAX_WAIT wait states have already been inserted, the data is captured and done pulses. No error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Local request to begin a read cycle |
| start_addr_i | input | AW | Target address taken with the request |
| bus_addr_o | output | AW | Address driven onto the bus, zero when no cycle is active |
| bus_rd_o | output | 1 | Read strobe to memory |
| bus_data_i | input | DW | Read data from memory |
| bus_rdy_i | input | 1 | Memory ready; low stretches the cycle |
| rd_data_o | output | DW | Most recently captured read data |
| done_o | output | 1 | One-clock pulse marking a successful capture |
| err_o | output | 1 | One-clock pulse marking an aborted cycle |

## Verification
The wait-state limit and the ready sample can decide the outcome on the same edge. This happens when the memory delay equals MAX_WAIT, so that ready rises exactly when the limit is reached. The bench sweeps the memory delay from zero to two beyond the limit. For that boundary delay it expects a capture and a done pulse with no error, and for one further delay it expects an abort with the old data kept. It also raises a second start while the strobe is active and checks that the bus address never leaves the first target.

// File: rtl/sync_read_master.sv
module sync_read_master #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int MAX_WAIT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rd_o,
  input  logic [DW-1:0] bus_data_i,
  input  logic          bus_rdy_i,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o,
  output logic          err_o
);
  localparam int WW = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);
  localparam logic [WW-1:0] WLIM = WW'(MAX_WAIT);

  typedef enum logic [2:0] {S_IDLE, S_ADR, S_STB, S_WAIT, S_FIN, S_ABT} st_t;

  st_t           st;
  logic [WW-1:0] wcnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  wire active  = (st == S_ADR) || (st == S_STB) || (st == S_WAIT);
  wire sampling = (st == S_STB) || (st == S_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      wcnt   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          addr_q <= start_addr_i;
          st     <= S_ADR;
        end
        S_ADR: begin
          wcnt <= '0;
          st   <= S_STB;
        end
        S_STB, S_WAIT: begin
          if (bus_rdy_i) begin
            data_q <= bus_data_i;
            st     <= S_FIN;
          end else if (wcnt == WLIM) begin
            st <= S_ABT;
          end else begin
            wcnt <= wcnt + 1'b1;
            st   <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_addr_o = active ? addr_q : '0;
  assign bus_rd_o   = sampling;
  assign rd_data_o  = data_q;
  assign done_o     = (st == S_FIN);
  assign err_o      = (st == S_ABT);
endmodule

module sync_read_master_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_rd_o,
  input logic          bus_rdy_i,
  input logic          done_o,
  input logic          err_o
);
  AST_RD_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rd_o) |-> $stable(bus_addr_o)); // R3
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_o && !bus_rdy_i) |=> ((bus_rd_o && $stable(bus_addr_o)) || err_o)); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(bus_rd_o && bus_rdy_i)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R4
  AST_END_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (done_o || err_o) |-> (!bus_rd_o && bus_addr_o == '0)); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_o |-> ($past(bus_rd_o && !bus_rdy_i) && !done_o)); // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o); // R8
endmodule

bind sync_read_master sync_read_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o),
  .bus_rdy_i(bus_rdy_i), .done_o(done_o), .err_o(err_o)
);

// File: tb/sync_read_master_test.sv
module sync_read_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int MW = 3;

  logic clk = 0;
  logic rst = 1;
  logic start_i = 0;
  logic [AW-1:0] start_addr_i = '0;
  logic [AW-1:0] bus_addr_o;
  logic bus_rd_o;
  logic [DW-1:0] bus_data_i;
  logic bus_rdy_i;
  logic [DW-1:0] rd_data_o;
  logic done_o, err_o;

  int checks = 0;
  int failures = 0;
  int mem_dly = 0;
  logic [7:0] mcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst || !bus_rd_o) mcnt <= 8'd0;
    else mcnt <= mcnt + 8'd1;
  end

  assign bus_rdy_i  = !(bus_rd_o && (int'(mcnt) < mem_dly));
  assign bus_data_i = bus_rdy_i ? (bus_addr_o ^ 8'h5A) : 8'hEE;

  sync_read_master #(.AW(AW), .DW(DW), .MAX_WAIT(MW)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o), .bus_data_i(bus_data_i),
    .bus_rdy_i(bus_rdy_i), .rd_data_o(rd_data_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  logic [DW-1:0] last_data = '0;

  task automatic run_txn(input logic [AW-1:0] a, input int d);
    int last;
    bit ok;
    ok = (d <= MW);
    last = ok ? 2 + d : 2 + MW;
    mem_dly = d;
    @(negedge clk);
    start_i = 1; start_addr_i = a;
    @(negedge clk);
    start_i = 0;
    chk(bus_addr_o == a && !bus_rd_o, "R2 addr in T1", {bus_rd_o, bus_addr_o}, {1'b0, a});
    @(negedge clk);
    chk(bus_addr_o == a && bus_rd_o, "R3 read in T2", {bus_rd_o, bus_addr_o}, {1'b1, a});
    start_i = 1; start_addr_i = ~a;
    for (int k = 2; k < last; k++) begin
      @(negedge clk);
      start_i = 0;
      chk(bus_rd_o && bus_addr_o == a && !done_o && !err_o, "R5 wait hold / R7 ignore start",
          {done_o, err_o, bus_rd_o, bus_addr_o}, {3'b001, a});
    end
    @(negedge clk);
    start_i = 0;
    if (ok) begin
      chk(done_o && !err_o, d == MW ? "R9 capture at limit" : "R4 done pulse",
          {done_o, err_o}, 2'b10);
      chk(rd_data_o == (a ^ 8'h5A), "R4 captured data", rd_data_o, a ^ 8'h5A);
      last_data = a ^ 8'h5A;
    end else begin
      chk(err_o && !done_o, "R8 abort flag", {done_o, err_o}, 2'b01);
      chk(rd_data_o == last_data, "R8 data kept", rd_data_o, last_data);
    end
    chk(!bus_rd_o && bus_addr_o == '0, "R6 release after end", {bus_rd_o, bus_addr_o}, '0);
    @(negedge clk);
    chk(!done_o && !err_o && !bus_rd_o && bus_addr_o == '0, "R6 idle / R7 no second cycle",
        {done_o, err_o, bus_rd_o, bus_addr_o}, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(bus_addr_o == '0 && !bus_rd_o && !done_o && !err_o, "R1 reset state",
        {done_o, err_o, bus_rd_o, bus_addr_o}, '0);
    for (int d = 0; d <= MW + 2; d++) begin
      run_txn(8'h00, d);
      run_txn(8'hFF, d);
      run_txn(8'h3C + 8'(d), d);
    end
    mem_dly = 5;
    @(negedge clk);
    start_i = 1; start_addr_i = 8'h77;
    repeat (3) begin
      @(negedge clk);
      start_i = 0;
    end
    chk(bus_rd_o, "R5 stretched before reset", bus_rd_o, 1);
    rst = 1;
    @(negedge clk);
    chk(bus_addr_o == '0 && !bus_rd_o && !done_o && !err_o, "R1 mid-cycle reset",
        {done_o, err_o, bus_rd_o, bus_addr_o}, '0);
    rst = 0;
    run_txn(8'h81, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule